// File: doc/BRIEF.md
# Subset Prefix Detector and Selector

This block looks at a tile of binary spike rows and, for every row, finds another row of the same tile whose spikes all occur in that row. Such a row is a reusable partial result: whatever was accumulated for it can be taken as the starting point, and only the remaining spike positions still need work. The block selects one such row per target row and emits the leftover bit mask. A downstream scheduler uses these results to skip redundant accumulation.

Rows are loaded one at a time through a write port while the block is idle. A start pulse begins a scan. The row under test is compared against every stored row at once, in the manner of a ternary content match. A selection tree then reduces the candidate set to a single winner. One result leaves per clock, in ascending row order, and a one-cycle done pulse follows the final row.

Top module: `spd_prefix_unit`

## Requirements
- R1: While rst_n is low at a clock edge, every output goes to zero and all stored rows are cleared to zero.
- R2: Row j is a candidate for row i when j differs from i, row j is not all-zero, and every set bit of row j is also set in row i. Identical rows count as candidates.
- R3: Among the candidates, the row with the largest number of set bits is reported in res_prefix, and res_has_prefix is 1.
- R4: When candidates tie on set-bit count, the one with the lowest row index is reported.
- R5: When a prefix is reported, res_suffix equals the target row's bits with the prefix row's bits cleared.
- R6: A row never reports itself. A row identical to the target qualifies only if its index is strictly lower than the target's index.
- R7: With no candidate, res_has_prefix is 0, res_prefix is 0, and res_suffix equals the full target row. An all-zero row never serves as a prefix.
- R8: A start pulse sampled while idle makes res_valid high for exactly ROWS consecutive cycles, beginning the next cycle, with res_row counting 0 to ROWS-1. While res_valid is low, res_row, res_has_prefix, res_prefix and res_suffix are 0.
- R9: done is high for exactly one cycle, the cycle right after the one carrying row ROWS-1.
- R10: Row writes and start pulses presented during a scan have no effect. Writes presented in the same cycle as an accepted start are stored before the scan begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write one tile row |
| load_row | input | IDX_W | Index of the row being written |
| load_bits | input | WIDTH | Spike bits of the row being written |
| start | input | 1 | Begin a scan of the whole tile |
| res_valid | output | 1 | A row result is present |
| res_row | output | IDX_W | Index of the row the result belongs to |
| res_has_prefix | output | 1 | A prefix row was found |
| res_prefix | output | IDX_W | Index of the chosen prefix row |
| res_suffix | output | WIDTH | Bits that still need accumulation |
| done | output | 1 | One-cycle end-of-scan pulse |

## Verification
On every cycle the assertions check several properties. Results must step through the rows in order, and done must follow the last row as a single pulse. No row may name itself as its prefix, and an absent prefix must report index 0. The selection tree's winner must be a real candidate from the match array, and stored rows must stay frozen while a scan runs. The actual choice of prefix is a different matter. Greatest overlap, lowest-index tie-break, the identical-row rule and the exact suffix bits depend on tile contents. Only the bench's directed and random tiles, compared each clock against a behavioural model, can show these.

// File: rtl/spd_pkg.sv
// Package: shared types for the subset prefix detector.
// Assumes nothing beyond standard SystemVerilog.
package spd_pkg;

    // Controller state: idle (accepting loads) or scanning rows.
    typedef enum logic {
        SPD_IDLE = 1'b0,
        SPD_SCAN = 1'b1
    } spd_state_e;

endpackage

// File: rtl/spd_row_store.sv
// Module: spd_row_store
// Holds the tile rows and a set-bit count per row, computed once at write time.
// Assumes: writes with an index at or above ROWS are dropped. While lock is
// high, no row changes.
module spd_row_store #(
    parameter int ROWS  = 32,
    parameter int WIDTH = 16,
    parameter int IDX_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lock,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [WIDTH-1:0] wr_bits,
    output logic [WIDTH-1:0] rows   [ROWS],
    output logic [CNT_W-1:0] counts [ROWS]
);

    // Count the set bits of one row.
    function automatic logic [CNT_W-1:0] ones(input logic [WIDTH-1:0] v);
        logic [CNT_W-1:0] n;
        n = '0;
        for (int b = 0; b < WIDTH; b++) begin
            n = n + CNT_W'(v[b]);
        end
        return n;
    endfunction

    // One storage slot per row, with a write-enable decode per slot.
    for (genvar g = 0; g < ROWS; g++) begin : g_slot
        logic hit;
        assign hit = wr_en && !lock && (wr_idx == IDX_W'(g));

        // Capture the row and its set-bit count on a permitted write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rows[g]   <= '0;
                counts[g] <= '0;
            end else if (hit) begin
                rows[g]   <= wr_bits;
                counts[g] <= ones(wr_bits);
            end
        end

        AST_LOCKED_ROW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
            lock |=> $stable(rows[g])) else $error("row changed during scan"); // R10
    end

endmodule

// File: rtl/spd_match_array.sv
// Module: spd_match_array
// Compares one query row against all stored rows at once and flags every
// candidate prefix: a non-zero stored row whose set bits are all present in the
// query. The query's own slot is excluded. An identical row only counts from a
// lower index.
// Assumes: q_idx names the slot that q_bits was read from.
module spd_match_array #(
    parameter int ROWS  = 32,
    parameter int WIDTH = 16,
    parameter int IDX_W = 5
) (
    input  logic [WIDTH-1:0] rows [ROWS],
    input  logic [WIDTH-1:0] q_bits,
    input  logic [IDX_W-1:0] q_idx,
    output logic [ROWS-1:0]  cand
);

    // One comparator per stored row, in the manner of a ternary content match.
    for (genvar g = 0; g < ROWS; g++) begin : g_cmp
        logic covered;
        logic nonzero;
        logic is_self;
        logic twin_after;

        assign covered    = ((rows[g] & ~q_bits) == '0);
        assign nonzero    = (rows[g] != '0);
        assign is_self    = (q_idx == IDX_W'(g));
        assign twin_after = (rows[g] == q_bits) && (IDX_W'(g) > q_idx);
        assign cand[g]    = covered && nonzero && !is_self && !twin_after;
    end

endmodule

// File: rtl/spd_select_tree.sv
// Module: spd_select_tree
// Binary reduction over the candidate flags. At each node the entry with more
// set bits wins. On equal counts the left (lower-index) entry wins, so the
// root holds the largest candidate with the lowest index.
// Assumes: counts[j] is the set-bit count of row j.
module spd_select_tree #(
    parameter int ROWS  = 32,
    parameter int IDX_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [ROWS-1:0]  cand,
    input  logic [CNT_W-1:0] counts [ROWS],
    output logic             sel_valid,
    output logic [IDX_W-1:0] sel_idx
);

    localparam int LVLS = IDX_W;
    localparam int NPAD = 1 << LVLS;

    // Level 0 holds the padded leaves. Each higher level halves the node count.
    for (genvar l = 0; l <= LVLS; l++) begin : g_lvl
        localparam int N = NPAD >> l;
        logic             v [N];
        logic [CNT_W-1:0] c [N];
        logic [IDX_W-1:0] x [N];

        if (l == 0) begin : g_leaf
            for (genvar k = 0; k < N; k++) begin : g_k
                if (k < ROWS) begin : g_real
                    assign v[k] = cand[k];
                    assign c[k] = counts[k];
                    assign x[k] = IDX_W'(k);
                end else begin : g_pad
                    assign v[k] = 1'b0;
                    assign c[k] = '0;
                    assign x[k] = '0;
                end
            end
        end else begin : g_node
            for (genvar k = 0; k < N; k++) begin : g_k
                logic take_left;
                assign take_left = g_lvl[l-1].v[2*k] &&
                                   (!g_lvl[l-1].v[2*k+1] ||
                                    g_lvl[l-1].c[2*k] >= g_lvl[l-1].c[2*k+1]);
                assign v[k] = g_lvl[l-1].v[2*k] || g_lvl[l-1].v[2*k+1];
                assign c[k] = take_left ? g_lvl[l-1].c[2*k] : g_lvl[l-1].c[2*k+1];
                assign x[k] = take_left ? g_lvl[l-1].x[2*k] : g_lvl[l-1].x[2*k+1];
            end
        end
    end

    assign sel_valid = g_lvl[LVLS].v[0];
    assign sel_idx   = g_lvl[LVLS].v[0] ? g_lvl[LVLS].x[0] : '0;

endmodule

// File: rtl/spd_prefix_unit.sv
// Module: spd_prefix_unit (top)
// Loads a tile of spike rows. On start, it scans them one per cycle and reports
// for each row its best subset prefix and the residual suffix mask. A done
// pulse follows the last row.
// Assumes: rows are loaded while idle. Loads and start during a scan are ignored.
module spd_prefix_unit
    import spd_pkg::*;
#(
    parameter int ROWS  = 32,
    parameter int WIDTH = 16,
    localparam int IDX_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CNT_W = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_row,
    input  logic [WIDTH-1:0] load_bits,
    input  logic             start,
    output logic             res_valid,
    output logic [IDX_W-1:0] res_row,
    output logic             res_has_prefix,
    output logic [IDX_W-1:0] res_prefix,
    output logic [WIDTH-1:0] res_suffix,
    output logic             done
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ROWS - 1);

    spd_state_e       state;
    logic [IDX_W-1:0] scan_idx;
    logic [WIDTH-1:0] rows   [ROWS];
    logic [CNT_W-1:0] counts [ROWS];
    logic [ROWS-1:0]  cand;
    logic             sel_valid;
    logic [IDX_W-1:0] sel_idx;
    logic [WIDTH-1:0] q_bits;
    logic [WIDTH-1:0] p_bits;
    logic             scanning;

    assign scanning = (state == SPD_SCAN);

    spd_row_store #(.ROWS(ROWS), .WIDTH(WIDTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .lock    (scanning),
        .wr_en   (load_en),
        .wr_idx  (load_row),
        .wr_bits (load_bits),
        .rows    (rows),
        .counts  (counts)
    );

    // Read the row under test and the chosen prefix row.
    assign q_bits = rows[scan_idx];
    assign p_bits = rows[sel_idx];

    spd_match_array #(.ROWS(ROWS), .WIDTH(WIDTH), .IDX_W(IDX_W)) u_match (
        .rows   (rows),
        .q_bits (q_bits),
        .q_idx  (scan_idx),
        .cand   (cand)
    );

    spd_select_tree #(.ROWS(ROWS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_select (
        .cand      (cand),
        .counts    (counts),
        .sel_valid (sel_valid),
        .sel_idx   (sel_idx)
    );

    // Scan controller and registered result outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= SPD_IDLE;
            scan_idx       <= '0;
            res_valid      <= 1'b0;
            res_row        <= '0;
            res_has_prefix <= 1'b0;
            res_prefix     <= '0;
            res_suffix     <= '0;
            done           <= 1'b0;
        end else begin
            done <= res_valid && (res_row == LAST);
            if (state == SPD_IDLE) begin
                res_valid      <= 1'b0;
                res_row        <= '0;
                res_has_prefix <= 1'b0;
                res_prefix     <= '0;
                res_suffix     <= '0;
                if (start) begin
                    state    <= SPD_SCAN;
                    scan_idx <= '0;
                end
            end else begin
                res_valid      <= 1'b1;
                res_row        <= scan_idx;
                res_has_prefix <= sel_valid;
                res_prefix     <= sel_valid ? sel_idx : '0;
                res_suffix     <= sel_valid ? (q_bits & ~p_bits) : q_bits;
                if (scan_idx == LAST) begin
                    state    <= SPD_IDLE;
                    scan_idx <= '0;
                end else begin
                    scan_idx <= scan_idx + 1'b1;
                end
            end
        end
    end

    AST_WINNER_IS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        scanning && sel_valid |-> cand[sel_idx]) else $error("winner not a candidate"); // R2
    AST_NONE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        scanning && !sel_valid |-> (cand == '0)) else $error("candidate lost"); // R7
    AST_NO_SELF_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && res_has_prefix |-> (res_prefix != res_row)) else $error("self prefix"); // R6
    AST_EMPTY_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_has_prefix |-> (res_prefix == '0)) else $error("stray index"); // R7
    AST_ROW_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_row != LAST) |=> res_valid && (res_row == IDX_W'($past(res_row) + 1'b1)))
        else $error("row order broken"); // R8
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && (res_row == LAST) |=> done && !res_valid) else $error("done missing"); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done too long"); // R9

endmodule

// File: tb/tb_spd_prefix_unit.sv
`timescale 1ns/1ps
module tb_spd_prefix_unit;

    localparam int ROWS  = 32;
    localparam int WIDTH = 16;
    localparam int IDX_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_en = 1'b0;
    logic [IDX_W-1:0] load_row = '0;
    logic [WIDTH-1:0] load_bits = '0;
    logic             start = 1'b0;
    logic             res_valid;
    logic [IDX_W-1:0] res_row;
    logic             res_has_prefix;
    logic [IDX_W-1:0] res_prefix;
    logic [WIDTH-1:0] res_suffix;
    logic             done;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    spd_prefix_unit #(.ROWS(ROWS), .WIDTH(WIDTH)) dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_row(load_row),
        .load_bits(load_bits), .start(start), .res_valid(res_valid),
        .res_row(res_row), .res_has_prefix(res_has_prefix), .res_prefix(res_prefix),
        .res_suffix(res_suffix), .done(done)
    );

    always #2 clk = ~clk;

    // Behavioural reference state.
    logic [WIDTH-1:0] m_mem [ROWS];
    bit               m_busy = 0;
    bit               m_last = 0;
    int               m_idx  = 0;
    bit               e_valid = 0;
    int               e_row = 0;
    bit               e_has = 0;
    int               e_pre = 0;
    logic [WIDTH-1:0] e_suf = '0;
    bit               e_done = 0;

    // Captured results of the latest scan.
    bit               c_has [ROWS];
    int               c_pre [ROWS];
    logic [WIDTH-1:0] c_suf [ROWS];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // Reference choice of prefix, written directly from the requirements.
    task automatic ref_pick(input int i, output bit has, output int pre, output logic [WIDTH-1:0] suf);
        int best;
        best = -1; has = 0; pre = 0;
        for (int j = 0; j < ROWS; j++) begin
            bit ok;
            ok = (j != i) && (m_mem[j] != 0) && ((m_mem[j] & ~m_mem[i]) == 0)
                 && !((m_mem[j] == m_mem[i]) && (j > i));
            if (ok && ($countones(m_mem[j]) > best)) begin
                best = $countones(m_mem[j]);
                pre  = j;
                has  = 1;
            end
        end
        suf = has ? (m_mem[i] & ~m_mem[pre]) : m_mem[i];
    endtask

    // Reference model stepped at every clock edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_busy = 0; m_last = 0; m_idx = 0;
            e_valid = 0; e_row = 0; e_has = 0; e_pre = 0; e_suf = '0; e_done = 0;
            for (int r = 0; r < ROWS; r++) m_mem[r] = '0;
        end else begin
            e_done = m_last;
            m_last = 0;
            if (m_busy) begin
                e_valid = 1;
                e_row   = m_idx;
                ref_pick(m_idx, e_has, e_pre, e_suf);
                if (m_idx == ROWS - 1) begin
                    m_busy = 0;
                    m_last = 1;
                end
                m_idx++;
            end else begin
                e_valid = 0; e_row = 0; e_has = 0; e_pre = 0; e_suf = '0;
                if (load_en) m_mem[load_row] = load_bits;
                if (start) begin
                    m_busy = 1;
                    m_idx  = 0;
                end
            end
        end
    end

    // Compare against the model away from the active edge, and capture results.
    always @(negedge clk) begin
        if (rst_n) begin
            check(res_valid == e_valid, "R8 valid", res_valid, e_valid);
            check(res_row == IDX_W'(e_row), "R8 row", res_row, e_row);
            check(res_has_prefix == e_has, "R3 has_prefix", res_has_prefix, e_has);
            check(res_prefix == IDX_W'(e_pre), "R4 prefix", res_prefix, e_pre);
            check(res_suffix == e_suf, "R5 suffix", res_suffix, e_suf);
            check(done == e_done, "R9 done", done, e_done);
            if (res_valid) begin
                c_has[res_row] = res_has_prefix;
                c_pre[res_row] = res_prefix;
                c_suf[res_row] = res_suffix;
            end
        end
    end

    task automatic put(input int idx, input logic [WIDTH-1:0] bits);
        @(negedge clk);
        load_en = 1; load_row = IDX_W'(idx); load_bits = bits;
        @(negedge clk);
        load_en = 0;
    endtask

    task automatic run_scan;
        int guard;
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        guard = 0;
        while (!done && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        check(done == 1'b1, "R9 done seen", done, 1);
        @(negedge clk);
    endtask

    task automatic finish_up;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run is one failed check.
    initial begin
        #400000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [WIDTH-1:0] gen [ROWS];
        repeat (3) @(negedge clk);
        // R1: outputs are zero while reset is held.
        check(res_valid == 0 && done == 0 && res_suffix == 0 && res_prefix == 0,
              "R1 reset outputs", res_suffix, 0);
        rst_n = 1;

        // R1: an immediate scan after reset sees cleared rows, so nothing has a prefix.
        run_scan();
        check(c_has[5] == 0 && c_suf[5] == 0, "R1 cleared rows", c_suf[5], 0);

        // Directed tile.
        put(0, 16'h0000);
        put(1, 16'h000F);
        put(2, 16'h000F);
        put(3, 16'h00FF);
        put(4, 16'h0003);
        put(5, 16'h00F0);
        put(6, 16'h0FFF);
        for (int r = 7; r < ROWS; r++) put(r, 16'h8000);
        run_scan();
        check(c_has[1] == 1 && c_pre[1] == 4, "R2 subset prefix row1", c_pre[1], 4);
        check(c_suf[1] == 16'h000C, "R5 suffix row1", c_suf[1], 16'h000C);
        check(c_has[2] == 1 && c_pre[2] == 1, "R6 identical lower row2", c_pre[2], 1);
        check(c_suf[2] == 16'h0000, "R5 suffix row2", c_suf[2], 0);
        check(c_pre[3] == 1, "R4 tie lowest row3", c_pre[3], 1);
        check(c_suf[3] == 16'h00F0, "R5 suffix row3", c_suf[3], 16'h00F0);
        check(c_has[6] == 1 && c_pre[6] == 3, "R3 largest row6", c_pre[6], 3);
        check(c_suf[6] == 16'h0F00, "R5 suffix row6", c_suf[6], 16'h0F00);
        check(c_has[4] == 0 && c_suf[4] == 16'h0003, "R7 no candidate row4", c_suf[4], 16'h0003);
        check(c_has[0] == 0 && c_pre[0] == 0, "R7 zero row0", c_pre[0], 0);
        check(c_has[7] == 0, "R6 first twin row7", c_has[7], 0);
        check(c_pre[31] == 7 && c_suf[31] == 0, "R4 twin tie row31", c_pre[31], 7);

        // R10: a write and a start during the scan are ignored.
        @(negedge clk);
        start = 1;
        @(negedge clk);
        start = 0;
        repeat (3) @(negedge clk);
        load_en = 1; load_row = 10; load_bits = 16'hFFFF; start = 1;
        @(negedge clk);
        load_en = 0; start = 0;
        while (!done) @(negedge clk);
        @(negedge clk);
        check(done == 0 && res_valid == 0, "R10 no restart", res_valid, 0);
        run_scan();
        check(c_pre[10] == 7 && c_suf[10] == 0, "R10 row10 unchanged", c_pre[10], 7);

        // Random tiles with planted subset relations, checked each clock by the model.
        for (int t = 0; t < 6; t++) begin
            for (int r = 0; r < ROWS; r++) begin
                if (r > 0 && ($urandom % 3) == 0)
                    gen[r] = gen[$urandom % r] | WIDTH'(1 << ($urandom % WIDTH));
                else if (($urandom % 8) == 0)
                    gen[r] = '0;
                else
                    gen[r] = WIDTH'($urandom & $urandom & $urandom);
                put(r, gen[r]);
            end
            run_scan();
        end
        finish_up();
    end

endmodule